// File: doc/BRIEF.md
# I2C Bit-Level Master Engine

This block turns single bus-event commands into SCL and SDA waveforms for an I2C controller. A higher-level sequencer hands it one command at a time over a valid/ready handshake. The commands are start, stop, byte write, byte read with acknowledge, byte read without acknowledge, and bus recovery. The engine plays the command out on the wires and pulses `done` when it has finished. A write returns the acknowledge level sampled from the addressed device. A read returns the received byte.

Every bus event is built from whole quarter periods of one SCL bit time. The quarter length in clock cycles is taken from `quarter_div` when a command is accepted. SDA is open-drain: the engine either pulls it low (`sda_oe` high) or releases it. SCL is driven directly. The SDA input passes through a two-flop synchronizer before it is sampled.

Bus recovery clocks nine pulses with SDA released and then runs a full stop. This frees a device that was stuck partway through a transfer.

Top module: `i2c_bit_engine`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `scl_o` is 1, `sda_oe` is 0, `cmd_ready` is 1 and `done` is 0.
- R2: A quarter lasts `quarter_div` clock cycles, and a value of 0 counts as 1. The value is captured when a command is accepted, so later changes to `quarter_div` do not affect the command in progress.
- R3: Start (code 1) takes 3 quarters. The levels are: SCL unchanged with SDA released, then SCL high with SDA released, then SCL high with SDA pulled low.
- R4: Stop (code 2) takes 4 quarters. The levels are: SCL low with SDA unchanged, then SCL low with SDA low, then SCL high with SDA low, then SCL high with SDA released.
- R5: Write (code 3) sends `wr_data` MSB first. Each bit takes 4 quarters: SCL low with SDA unchanged, then SCL low with SDA set to the bit (pulled low for a 0), then SCL high for two quarters. The command takes 37 quarters, ending with one quarter of SCL low.
- R6: The ninth clock of a write releases SDA in its second quarter. The line is sampled at the end of its second high quarter, and that level is returned on `ack_bit` (0 = acknowledge, 1 = no acknowledge).
- R7: A read (codes 4 and 5) keeps SDA released for 8 bits. Each bit is one quarter SCL low, then two quarters SCL high, and the line is sampled at the end of the first high quarter. The byte is assembled MSB first into `rd_data`. This holds for quarter lengths of 2 cycles or more.
- R8: After the eighth read bit, the acknowledge clock takes 4 quarters. Code 4 pulls SDA low and code 5 releases it. SCL is low for two quarters and high for two, and one more quarter with SCL low follows. A read takes 29 quarters.
- R9: Recovery (code 6) gives 9 pulses with SDA released, each pulse two quarters low and two quarters high. A stop as in R4 follows. The command takes 40 quarters.
- R10: A command is accepted when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for exactly quarters × quarter length cycles after acceptance. `done` is high for one cycle right after that, and `rd_data`/`ack_bit` are valid in that cycle.
- R11: Codes 0 and 7 are accepted but leave SCL and SDA unchanged, and `done` follows in the next cycle.
- R12: A command offered while `cmd_ready` is low is not taken and does not alter the sequence on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_code | input | 3 | Command code (see R3–R11) |
| wr_data | input | 8 | Byte for a write command |
| quarter_div | input | 16 | Quarter length in clock cycles (0 treated as 1) |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte received by the last read |
| ack_bit | output | 1 | Acknowledge level sampled by the last write |
| scl_o | output | 1 | SCL level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Level seen on the SDA line |

## Verification
The wire levels change at the accepting clock edge and then once every quarter-length cycles. `done` arrives exactly N × quarter-length cycles after acceptance, with N being 3, 4, 37, 29 or 40 depending on the command. For codes 0 and 7, `done` arrives one cycle after acceptance. For each command, the driver expands the expected quarter levels into one entry per clock cycle. The monitor samples on falling edges and uses up one entry for each cycle in which `cmd_ready` is low. At `done` it requires the queue to be empty and compares `rd_data` or `ack_bit`, so both a wrong duration and a wrong level are reported. The responder model changes SDA only while SCL is low, and the two-flop synchronizer delay is covered by running reads with quarter lengths of 2 cycles or more.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;

    localparam int CNT_W = 5;

    typedef enum logic [2:0] {
        CMD_NOP_LO  = 3'd0,
        CMD_START   = 3'd1,
        CMD_STOP    = 3'd2,
        CMD_WRITE   = 3'd3,
        CMD_RD_ACK  = 3'd4,
        CMD_RD_NACK = 3'd5,
        CMD_RECOVER = 3'd6,
        CMD_NOP_HI  = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_STOP,
        PH_WBIT,
        PH_RBIT,
        PH_RACK,
        PH_TAIL,
        PH_PULSE
    } phase_e;

    typedef struct packed {
        logic scl;
        logic sda_low;
    } drive_t;

    typedef struct packed {
        phase_e             ph;
        logic [1:0]         q;
        logic [CNT_W-1:0]   bit_idx;
    } step_t;

    // Index of the final quarter inside one bit slot of a phase.
    function automatic logic [1:0] last_quarter(phase_e ph);
        case (ph)
            PH_START, PH_RBIT: return 2'd2;
            PH_TAIL, PH_IDLE:  return 2'd0;
            default:           return 2'd3;
        endcase
    endfunction

    // Wire levels for the quarter described by s; hold carries levels that persist.
    function automatic drive_t drive_of(step_t s, drive_t hold, logic wr_low, logic ack_low);
        drive_t d;
        d = hold;
        case (s.ph)
            PH_START: begin
                if (s.q != 2'd0) d.scl = 1'b1;
                d.sda_low = (s.q == 2'd2);
            end
            PH_STOP: begin
                d.scl = s.q[1];
                if (s.q == 2'd1 || s.q == 2'd2) d.sda_low = 1'b1;
                if (s.q == 2'd3)                d.sda_low = 1'b0;
            end
            PH_WBIT: begin
                d.scl = s.q[1];
                if (s.q == 2'd1) d.sda_low = wr_low;
            end
            PH_RBIT: begin
                d.scl     = (s.q != 2'd0);
                d.sda_low = 1'b0;
            end
            PH_RACK: begin
                d.scl = s.q[1];
                if (s.q == 2'd1) d.sda_low = ack_low;
            end
            PH_TAIL: d.scl = 1'b0;
            PH_PULSE: begin
                d.scl     = s.q[1];
                d.sda_low = 1'b0;
            end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/i2c_quarter_timer.sv
module i2c_quarter_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             en,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);
    logic [DIV_W-1:0] div_r;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_eff;

    assign div_eff = (div_in == '0) ? DIV_W'(1) : div_in;
    assign tick    = en && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_r <= DIV_W'(1);
            cnt   <= '0;
        end else if (start) begin
            div_r <= div_eff;
            cnt   <= div_eff - DIV_W'(1);
        end else if (tick) begin
            cnt   <= div_r - DIV_W'(1);
        end else if (cnt != '0) begin
            cnt   <= cnt - DIV_W'(1);
        end
    end

    // R2: the quarter counter never reaches the captured length
    p_cnt_below_div_r2: assert property (@(posedge clk) disable iff (rst)
        cnt < div_r);

endmodule

// File: rtl/i2c_sda_sync.sv
module i2c_sda_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES < 2) begin : g_single
            logic ff;
            always_ff @(posedge clk) begin
                if (rst) ff <= 1'b1;
                else     ff <= d;
            end
            assign q = ff;
        end else begin : g_chain
            logic [STAGES-1:0] ff;
            always_ff @(posedge clk) begin
                if (rst) ff <= '1;
                else     ff <= {ff[STAGES-2:0], d};
            end
            assign q = ff[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/i2c_bit_sequencer.sv
module i2c_bit_sequencer
    import i2c_bit_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PULSES = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick,
    input  logic              sda_s,
    output logic              cmd_ready,
    output logic              accept,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              ack_bit,
    output logic              scl_o,
    output logic              sda_oe
);
    localparam logic [CNT_W-1:0] BIT_ACK   = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] BIT_RLAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] BIT_PLAST = CNT_W'(PULSES - 1);

    step_t             cur, nxt;
    drive_t            drv_r, drv_n;
    logic              fin, last_q, wr_low;
    logic              ack_low_r, is_read_r, ack_r, done_r;
    logic [DATA_W-1:0] wr_r, sh_r, rd_r, wsh;

    assign cmd_ready = (cur.ph == PH_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign busy      = !cmd_ready;
    assign last_q    = (cur.q == last_quarter(cur.ph));

    always_comb begin
        nxt = cur;
        fin = 1'b0;
        if (cur.ph == PH_IDLE) begin
            if (accept) begin
                nxt.q       = 2'd0;
                nxt.bit_idx = '0;
                case (cmd_e'(cmd_code))
                    CMD_START:               nxt.ph = PH_START;
                    CMD_STOP:                nxt.ph = PH_STOP;
                    CMD_WRITE:               nxt.ph = PH_WBIT;
                    CMD_RD_ACK, CMD_RD_NACK: nxt.ph = PH_RBIT;
                    CMD_RECOVER:             nxt.ph = PH_PULSE;
                    default:                 fin    = 1'b1;
                endcase
            end
        end else if (tick) begin
            if (!last_q) begin
                nxt.q = cur.q + 2'd1;
            end else begin
                nxt.q = 2'd0;
                case (cur.ph)
                    PH_WBIT: begin
                        if (cur.bit_idx == BIT_ACK) begin
                            nxt.ph      = PH_TAIL;
                            nxt.bit_idx = '0;
                        end else begin
                            nxt.bit_idx = cur.bit_idx + 1'b1;
                        end
                    end
                    PH_RBIT: begin
                        if (cur.bit_idx == BIT_RLAST) begin
                            nxt.ph      = PH_RACK;
                            nxt.bit_idx = '0;
                        end else begin
                            nxt.bit_idx = cur.bit_idx + 1'b1;
                        end
                    end
                    PH_RACK: nxt.ph = PH_TAIL;
                    PH_PULSE: begin
                        if (cur.bit_idx == BIT_PLAST) begin
                            nxt.ph      = PH_STOP;
                            nxt.bit_idx = '0;
                        end else begin
                            nxt.bit_idx = cur.bit_idx + 1'b1;
                        end
                    end
                    default: begin
                        nxt.ph = PH_IDLE;
                        fin    = 1'b1;
                    end
                endcase
            end
        end
    end

    always_comb begin
        wsh    = wr_r << nxt.bit_idx;
        wr_low = (nxt.bit_idx < BIT_ACK) && !wsh[DATA_W-1];
        drv_n  = drive_of(nxt, drv_r, wr_low, ack_low_r);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= '{ph: PH_IDLE, q: 2'd0, bit_idx: '0};
            drv_r     <= '{scl: 1'b1, sda_low: 1'b0};
            done_r    <= 1'b0;
            wr_r      <= '0;
            sh_r      <= '0;
            rd_r      <= '0;
            ack_r     <= 1'b1;
            ack_low_r <= 1'b0;
            is_read_r <= 1'b0;
        end else begin
            cur    <= nxt;
            drv_r  <= drv_n;
            done_r <= fin;
            if (accept) begin
                wr_r      <= wr_data;
                ack_low_r <= (cmd_e'(cmd_code) == CMD_RD_ACK);
                is_read_r <= (cmd_e'(cmd_code) == CMD_RD_ACK) ||
                             (cmd_e'(cmd_code) == CMD_RD_NACK);
            end
            if (tick && cur.ph == PH_WBIT && cur.bit_idx == BIT_ACK && last_q)
                ack_r <= sda_s;
            if (tick && cur.ph == PH_RBIT && cur.q == 2'd1)
                sh_r <= {sh_r[DATA_W-2:0], sda_s};
            if (fin && is_read_r)
                rd_r <= sh_r;
        end
    end

    assign done    = done_r;
    assign rd_data = rd_r;
    assign ack_bit = ack_r;
    assign scl_o   = drv_r.scl;
    assign sda_oe  = drv_r.sda_low;

    // R10: a completion pulse only appears while the engine is idle again
    p_done_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> cmd_ready);

    // R10: an accepted command either starts a phase or completes next cycle
    p_accept_moves_r10: assert property (@(posedge clk) disable iff (rst)
        accept |=> (busy || done));

    // R5: inside data and pulse slots SDA only moves while SCL is low
    p_sda_moves_scl_low_r5: assert property (@(posedge clk) disable iff (rst)
        ((cur.ph == PH_WBIT || cur.ph == PH_RBIT || cur.ph == PH_RACK ||
          cur.ph == PH_PULSE) && !$stable(drv_r.sda_low)) |-> !drv_r.scl);

    // R3: the start condition pulls SDA low with SCL high
    p_start_edge_r3: assert property (@(posedge clk) disable iff (rst)
        (cur.ph == PH_START && $rose(drv_r.sda_low)) |-> drv_r.scl);

    // R4: the stop condition releases SDA with SCL high
    p_stop_edge_r4: assert property (@(posedge clk) disable iff (rst)
        (cur.ph == PH_STOP && $fell(drv_r.sda_low)) |-> drv_r.scl);

    // R9: recovery pulses never pull SDA
    p_pulse_release_r9: assert property (@(posedge clk) disable iff (rst)
        (cur.ph == PH_PULSE) |-> !drv_r.sda_low);

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
    import i2c_bit_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 16,
    parameter int PULSES      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DIV_W-1:0]  quarter_div,
    output logic              cmd_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              ack_bit,
    output logic              scl_o,
    output logic              sda_oe,
    input  logic              sda_i
);
    logic tick, accept, busy, sda_s;

    i2c_sda_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sda_i),
        .q   (sda_s)
    );

    i2c_quarter_timer #(.DIV_W(DIV_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (accept),
        .en     (busy),
        .div_in (quarter_div),
        .tick   (tick)
    );

    i2c_bit_sequencer #(.DATA_W(DATA_W), .PULSES(PULSES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .wr_data   (wr_data),
        .tick      (tick),
        .sda_s     (sda_s),
        .cmd_ready (cmd_ready),
        .accept    (accept),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .ack_bit   (ack_bit),
        .scl_o     (scl_o),
        .sda_oe    (sda_oe)
    );
endmodule

// File: tb/test_i2c_bit_engine.sv
module test_i2c_bit_engine;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [15:0] quarter_div = 16'd4;
    logic       cmd_ready, done, ack_bit, scl_o, sda_oe, sda_i;
    logic [7:0] rd_data;

    always #2 clk = ~clk;

    int         slave_mode = 0;
    logic [7:0] slave_byte = 8'd0;
    logic       slave_low = 1'b0;
    int         rises = 0;
    logic       scl_prev = 1'b1;
    assign sda_i = !(sda_oe || slave_low);

    int errors = 0, checks = 0;
    logic [1:0] bus_q[$];
    int         tag_q[$];
    int         res_kind[$];
    logic [7:0] res_val[$];
    int         res_tag[$];
    int         dv = 1;
    logic       m_scl = 1'b1, m_sdl = 1'b0;
    bit         finished = 1'b0;
    logic [1:0] mon_e;
    int         mon_t, mon_k;
    logic [7:0] mon_v;

    i2c_bit_engine i_i2c_bit_engine (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .wr_data(wr_data), .quarter_div(quarter_div), .cmd_ready(cmd_ready),
        .done(done), .rd_data(rd_data), .ack_bit(ack_bit), .scl_o(scl_o),
        .sda_oe(sda_oe), .sda_i(sda_i)
    );

    // responder: changes SDA only while SCL is low
    always @(negedge clk) begin
        if (cmd_ready) rises = 0;
        else if (scl_o && !scl_prev) rises = rises + 1;
        scl_prev = scl_o;
        if (slave_mode == 2) begin
            if (!scl_o) slave_low = (rises < 8) ? !slave_byte[7 - rises] : 1'b0;
        end else begin
            slave_low = (slave_mode == 1);
        end
    end

    // monitor: one expected bus entry per busy cycle, results at done
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (!cmd_ready) begin
                checks++;
                if (bus_q.size() == 0) begin
                    errors++;
                    $display("FAIL R10: busy cycle, actual busy=1 expected busy=0");
                end else begin
                    mon_e = bus_q.pop_front();
                    mon_t = tag_q.pop_front();
                    if ({scl_o, sda_oe} !== mon_e) begin
                        errors++;
                        $display("FAIL R%0d: scl/sda_oe actual %b expected %b", mon_t, {scl_o, sda_oe}, mon_e);
                    end
                end
            end
            if (done) begin
                checks++;
                if (bus_q.size() != 0) begin
                    errors++;
                    $display("FAIL R10: done early, actual remaining=%0d expected 0", bus_q.size());
                    bus_q.delete();
                    tag_q.delete();
                end
                if (res_kind.size() == 0) begin
                    errors++;
                    $display("FAIL R10: done pulse, actual 1 expected 0");
                end else begin
                    mon_k = res_kind.pop_front();
                    mon_v = res_val.pop_front();
                    mon_t = res_tag.pop_front();
                    if (mon_k == 1) begin
                        checks++;
                        if (ack_bit !== mon_v[0]) begin
                            errors++;
                            $display("FAIL R%0d: ack_bit actual %b expected %b", mon_t, ack_bit, mon_v[0]);
                        end
                    end else if (mon_k == 2) begin
                        checks++;
                        if (rd_data !== mon_v) begin
                            errors++;
                            $display("FAIL R%0d: rd_data actual %h expected %h", mon_t, rd_data, mon_v);
                        end
                    end
                end
            end
        end
    end

    task automatic qt(input logic s, input logic l, input int tag);
        for (int i = 0; i < dv; i++) begin
            bus_q.push_back({s, l});
            tag_q.push_back(tag);
        end
        m_scl = s;
        m_sdl = l;
    endtask

    task automatic push_res(input int kind, input logic [7:0] v, input int tag);
        res_kind.push_back(kind);
        res_val.push_back(v);
        res_tag.push_back(tag);
    endtask

    // R3 start pattern
    task automatic exp_start();
        qt(m_scl, 1'b0, 3); qt(1'b1, 1'b0, 3); qt(1'b1, 1'b1, 3);
        push_res(0, 8'd0, 3);
    endtask

    // R4 stop pattern
    task automatic exp_stop(input int tag);
        qt(1'b0, m_sdl, tag); qt(1'b0, 1'b1, tag); qt(1'b1, 1'b1, tag); qt(1'b1, 1'b0, tag);
    endtask

    // R5 data bits, R6 acknowledge slot
    task automatic exp_write(input logic [7:0] d, input logic ackv);
        for (int i = 0; i < 8; i++) begin
            qt(1'b0, m_sdl, 5); qt(1'b0, !d[7 - i], 5); qt(1'b1, m_sdl, 5); qt(1'b1, m_sdl, 5);
        end
        qt(1'b0, m_sdl, 6); qt(1'b0, 1'b0, 6); qt(1'b1, 1'b0, 6); qt(1'b1, 1'b0, 6);
        qt(1'b0, m_sdl, 5);
        push_res(1, {7'd0, ackv}, 6);
    endtask

    // R7 read bits, R8 acknowledge driven by the engine
    task automatic exp_read(input logic ack_low, input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            qt(1'b0, 1'b0, 7); qt(1'b1, 1'b0, 7); qt(1'b1, 1'b0, 7);
        end
        qt(1'b0, m_sdl, 8); qt(1'b0, ack_low, 8); qt(1'b1, m_sdl, 8); qt(1'b1, m_sdl, 8);
        qt(1'b0, m_sdl, 8);
        push_res(2, b, 7);
    endtask

    // R9 recovery pulses then stop
    task automatic exp_recover();
        for (int i = 0; i < 9; i++) begin
            qt(1'b0, 1'b0, 9); qt(1'b0, 1'b0, 9); qt(1'b1, 1'b0, 9); qt(1'b1, 1'b0, 9);
        end
        exp_stop(9);
        push_res(0, 8'd0, 9);
    endtask

    task automatic run_cmd(input logic [2:0] code, input logic [7:0] data,
                           input logic [15:0] div, input int smode,
                           input logic [7:0] sbyte, input bit poke);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        dv = (div == 16'd0) ? 1 : int'(div);
        slave_mode = smode;
        slave_byte = sbyte;
        case (code)
            3'd1: exp_start();
            3'd2: begin exp_stop(4); push_res(0, 8'd0, 4); end
            3'd3: exp_write(data, (smode == 1) ? 1'b0 : 1'b1);
            3'd4: exp_read(1'b1, sbyte);
            3'd5: exp_read(1'b0, sbyte);
            3'd6: exp_recover();
            default: push_res(0, 8'd0, 11); // R11 no bus activity
        endcase
        quarter_div = div;
        cmd_code    = code;
        wr_data     = data;
        cmd_valid   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (poke) begin
            // R12 offer a recovery while busy; R2 change the divider mid-command
            repeat (3) @(negedge clk);
            cmd_valid   = 1'b1;
            cmd_code    = 3'd6;
            quarter_div = 16'd9;
            repeat (4) @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        checks++; if (scl_o !== 1'b1) begin errors++; $display("FAIL R1: scl_o actual %b expected 1", scl_o); end
        checks++; if (sda_oe !== 1'b0) begin errors++; $display("FAIL R1: sda_oe actual %b expected 0", sda_oe); end
        rst = 1'b0;
        @(negedge clk);
        checks++; if (cmd_ready !== 1'b1) begin errors++; $display("FAIL R1: cmd_ready actual %b expected 1", cmd_ready); end
        checks++; if (done !== 1'b0) begin errors++; $display("FAIL R1: done actual %b expected 0", done); end
        checks++; if (scl_o !== 1'b1 || sda_oe !== 1'b0) begin errors++; $display("FAIL R1: bus actual %b%b expected 10", scl_o, sda_oe); end

        // R3 R5 R6 R7 R8 R4 at quarter length 4
        run_cmd(3'd1, 8'h00, 16'd4, 0, 8'h00, 1'b0);
        run_cmd(3'd3, 8'hA5, 16'd4, 1, 8'h00, 1'b0);
        run_cmd(3'd3, 8'h3C, 16'd4, 0, 8'h00, 1'b0);
        run_cmd(3'd1, 8'h00, 16'd4, 0, 8'h00, 1'b0);
        run_cmd(3'd4, 8'h00, 16'd4, 2, 8'h96, 1'b0);
        run_cmd(3'd4, 8'h00, 16'd4, 2, 8'h00, 1'b0);
        run_cmd(3'd5, 8'h00, 16'd4, 2, 8'hFF, 1'b0);
        run_cmd(3'd2, 8'h00, 16'd4, 0, 8'h00, 1'b0);
        // R2 divider value 0 behaves as 1
        run_cmd(3'd1, 8'h00, 16'd0, 0, 8'h00, 1'b0);
        run_cmd(3'd3, 8'h01, 16'd0, 1, 8'h00, 1'b0);
        run_cmd(3'd3, 8'h80, 16'd0, 0, 8'h00, 1'b0);
        run_cmd(3'd2, 8'h00, 16'd0, 0, 8'h00, 1'b0);
        // R9 recovery at quarter length 3
        run_cmd(3'd6, 8'h00, 16'd3, 0, 8'h00, 1'b0);
        // R11 undefined codes
        run_cmd(3'd0, 8'hFF, 16'd3, 0, 8'h00, 1'b0);
        run_cmd(3'd7, 8'hFF, 16'd3, 0, 8'h00, 1'b0);
        // R12 and R2 capture: busy offer and divider change during a write
        run_cmd(3'd1, 8'h00, 16'd5, 0, 8'h00, 1'b0);
        run_cmd(3'd3, 8'hC3, 16'd5, 1, 8'h00, 1'b1);
        // R7 shortest supported read quarter
        run_cmd(3'd5, 8'h00, 16'd2, 2, 8'h5A, 1'b0);
        run_cmd(3'd2, 8'h00, 16'd2, 0, 8'h00, 1'b0);

        repeat (3) @(negedge clk);
        checks++;
        if (bus_q.size() != 0 || res_kind.size() != 0) begin
            errors++;
            $display("FAIL R10: leftover expectations actual %0d/%0d expected 0/0", bus_q.size(), res_kind.size());
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL R10: watchdog expired, actual hung expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule